// File: doc/BRIEF.md
# Password Check with Attempt Counters

This block holds sixteen 24-bit passwords, a write password and a read password for each of eight sets. It compares a presented password against the one picked by a select nibble. Each stored password has its own 8-bit attempt counter. Every wrong presentation uses up one more counter bit. A correct presentation refills the counter, unless all bits are already spent. A spent counter locks its password for good.

At most one password is verified at any moment. The block reports which one, and the read and write rights it gives on each set. A small write port lets software replace the passwords of a set, but only while that set's write password is the verified one. A privilege-clear input drops the verified password without touching the stored passwords or the counters.

Top module: `pwd_gate`

## Requirements
- R1: `sel[3]` picks the kind of password: 0 means write password, 1 means read password. `sel[2:0]` picks the set. The storage index is the whole nibble.
- R2: The presented value is `{pw_hi, pw_mid, pw_lo}`, with `pw_hi` as the most significant byte. One cycle after `go`, `done` pulses for one cycle. With it come `pass` and the updated counter on `res_cnt`.
- R3: On a wrong password whose counter is not zero, the counter shifts left by one and a zero fills the low bit (FF, FE, FC, ..., 00).
- R4: On a correct password whose counter is not zero, the counter becomes FF and that password becomes the verified one.
- R5: Once a counter reads 00, any presentation of that password fails, even with the right value, and the counter stays 00.
- R6: Only one password is verified at a time. Any presentation, whether it passes, fails or hits a locked counter, removes the privilege held before it.
- R7: A verified write password gives read and write rights on its set (`set_rd_ok` and `set_wr_ok` bit equal to the set). A verified read password gives only the read bit.
- R8: A write through the write port changes the stored password `wr_sel` only while the verified password is the write password of set `wr_sel[2:0]`. Otherwise the write is ignored.
- R9: `clr_priv` clears the verified privilege on the next edge. If it comes in the same cycle as a `go`, it wins over any grant, but the counter update and the result are still produced.
- R10: Select 0111 is the secure code, which is write password 7. Verifying it gives read and write rights on set 7.
- R11: After `rst_n`, every counter is FF, no password is verified, and the password at index i holds `PW_SEED + i` (default seed 0x3C5A00).
- R12: When `go` and a port write fall in the same cycle, the write is allowed or refused by the privilege held before that edge. The comparison uses the stored value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads default passwords and full counters |
| clr_priv | input | 1 | Drops the verified privilege |
| go | input | 1 | Starts one password check |
| sel | input | 4 | Password select: kind bit and set number |
| pw_hi | input | 8 | Presented password, most significant byte |
| pw_mid | input | 8 | Presented password, middle byte |
| pw_lo | input | 8 | Presented password, least significant byte |
| wr_en | input | 1 | Password write request |
| wr_sel | input | 4 | Index of the password to replace |
| wr_data | input | 24 | New password value |
| cnt_rd_sel | input | 4 | Index of the counter to read back |
| done | output | 1 | One-cycle pulse with each check result |
| pass | output | 1 | Result of the last check |
| res_cnt | output | 8 | Counter value after the last check |
| cnt_rd | output | 8 | Counter selected by `cnt_rd_sel` |
| act_valid | output | 1 | A password is currently verified |
| act_sel | output | 4 | Select nibble of the verified password |
| set_rd_ok | output | 8 | Per-set read right |
| set_wr_ok | output | 8 | Per-set write right |

## Verification
A check and a password write can land on the same clock edge. The bench provokes this in two ways. First, it re-presents the old value of a write password while writing a new value into that same slot; the check must pass against the old value. Second, it presents a wrong password for another set while writing under the privilege that this check is about to cancel; the write must still take effect. Both outcomes are then judged through later checks: presenting the old value and the new value shows which one is stored. The bench also puts `clr_priv` on the same edge as a correct check, to show that the result still arrives but the privilege does not.

// File: rtl/pwd_gate.sv
module pwd_gate #(
  parameter int          NSET    = 8,
  parameter int          CNT_W   = 8,
  parameter logic [23:0] PW_SEED = 24'h3C5A00
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_priv,
  input  logic                        go,
  input  logic [$clog2(2*NSET)-1:0]   sel,
  input  logic [7:0]                  pw_hi,
  input  logic [7:0]                  pw_mid,
  input  logic [7:0]                  pw_lo,
  input  logic                        wr_en,
  input  logic [$clog2(2*NSET)-1:0]   wr_sel,
  input  logic [23:0]                 wr_data,
  input  logic [$clog2(2*NSET)-1:0]   cnt_rd_sel,
  output logic                        done,
  output logic                        pass,
  output logic [CNT_W-1:0]            res_cnt,
  output logic [CNT_W-1:0]            cnt_rd,
  output logic                        act_valid,
  output logic [$clog2(2*NSET)-1:0]   act_sel,
  output logic [NSET-1:0]             set_rd_ok,
  output logic [NSET-1:0]             set_wr_ok
);
  localparam int NPW = 2 * NSET;
  localparam int IW  = $clog2(NPW);
  localparam int SW  = $clog2(NSET);

  logic [23:0]      pw_q  [NPW];
  logic [CNT_W-1:0] cnt_q [NPW];

  wire [23:0]      pw_pres = {pw_hi, pw_mid, pw_lo};
  wire [CNT_W-1:0] cur_cnt = cnt_q[sel];
  wire             locked  = (cur_cnt == '0);
  wire             hit     = !locked && (pw_q[sel] == pw_pres);
  wire [CNT_W-1:0] nxt_cnt = locked ? '0 : (hit ? '1 : {cur_cnt[CNT_W-2:0], 1'b0});
  wire             wr_gate = act_valid && !act_sel[IW-1] && (act_sel[SW-1:0] == wr_sel[SW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPW; i++) begin
        pw_q[i]  <= PW_SEED + 24'(i);
        cnt_q[i] <= '1;
      end
      done      <= 1'b0;
      pass      <= 1'b0;
      res_cnt   <= '1;
      act_valid <= 1'b0;
      act_sel   <= '0;
    end else begin
      done <= go;
      if (go) begin
        pass         <= hit;
        res_cnt      <= nxt_cnt;
        cnt_q[sel]   <= nxt_cnt;
        act_sel      <= sel;
      end
      if (clr_priv)  act_valid <= 1'b0;
      else if (go)   act_valid <= hit;
      if (wr_en && wr_gate) pw_q[wr_sel] <= wr_data;
    end
  end

  assign cnt_rd = cnt_q[cnt_rd_sel];

  for (genvar k = 0; k < NSET; k++) begin : g_set
    assign set_rd_ok[k] = act_valid && (act_sel[SW-1:0] == SW'(k));
    assign set_wr_ok[k] = set_rd_ok[k] && !act_sel[IW-1];
  end
endmodule

// File: rtl/pwd_gate_chk.sv
module pwd_gate_chk #(
  parameter int NSET  = 8,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_priv,
  input logic             go,
  input logic             done,
  input logic             pass,
  input logic [CNT_W-1:0] res_cnt,
  input logic             act_valid,
  input logic [NSET-1:0]  set_rd_ok,
  input logic [NSET-1:0]  set_wr_ok
);
  p_done_follows_go_r2: assert property (@(posedge clk) disable iff (!rst_n) go |=> done);
  p_done_single_r2:     assert property (@(posedge clk) disable iff (!rst_n) !go |=> !done);
  p_fail_spends_r3:     assert property (@(posedge clk) disable iff (!rst_n) (done && !pass) |-> (res_cnt != '1));
  p_pass_full_r4:       assert property (@(posedge clk) disable iff (!rst_n) (done && pass) |-> (res_cnt == '1));
  p_pass_grants_r4:     assert property (@(posedge clk) disable iff (!rst_n) (done && pass && !$past(clr_priv)) |-> act_valid);
  p_lock_denies_r5:     assert property (@(posedge clk) disable iff (!rst_n) (done && res_cnt == '0) |-> !pass);
  p_single_priv_r6:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0(set_rd_ok) && $onehot0(set_wr_ok));
  p_fail_cancels_r6:    assert property (@(posedge clk) disable iff (!rst_n) (done && !pass) |-> !act_valid);
  p_wr_has_rd_r7:       assert property (@(posedge clk) disable iff (!rst_n) $countones(set_wr_ok) <= $countones(set_rd_ok));
  p_clear_drops_r9:     assert property (@(posedge clk) disable iff (!rst_n) clr_priv |=> !act_valid);
endmodule

bind pwd_gate pwd_gate_chk #(.NSET(NSET), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_priv(clr_priv), .go(go), .done(done), .pass(pass),
  .res_cnt(res_cnt), .act_valid(act_valid), .set_rd_ok(set_rd_ok), .set_wr_ok(set_wr_ok)
);

// File: tb/pwd_gate_bench.sv
`timescale 1ns/1ps
module pwd_gate_bench;
  logic clk = 0, rst_n = 0, clr_priv = 0, go = 0, wr_en = 0;
  logic [3:0] sel = 0, wr_sel = 0, cnt_rd_sel = 0;
  logic [7:0] pw_hi = 0, pw_mid = 0, pw_lo = 0;
  logic [23:0] wr_data = 0;
  logic done, pass, act_valid;
  logic [7:0] res_cnt, cnt_rd, set_rd_ok, set_wr_ok;
  logic [3:0] act_sel;

  always #2 clk = ~clk;

  pwd_gate u_pwd_gate (.*);

  int errors = 0, checks = 0;
  logic [8:0] sb_q[$];
  logic [23:0] m_pw [16];
  logic [7:0]  m_cnt[16];
  bit          m_act = 0;
  logic [3:0]  m_sel = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [8:0] e;
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: result %h with nothing expected", {pass, res_cnt});
      end else begin
        e = sb_q.pop_front();
        chk("R2/R3/R4/R5 result", {pass, res_cnt}, e);
      end
    end
  end

  task automatic cycle(bit g, logic [3:0] s, logic [23:0] p, bit w, logic [3:0] ws, logic [23:0] wd, bit c);
    bit ok_w, lk, hit;
    logic [7:0] nc;
    go = g; sel = s; {pw_hi, pw_mid, pw_lo} = p;
    wr_en = w; wr_sel = ws; wr_data = wd; clr_priv = c;
    ok_w = m_act && !m_sel[3] && (m_sel[2:0] == ws[2:0]);
    if (g) begin
      lk  = (m_cnt[s] == 8'h00);
      hit = !lk && (m_pw[s] == p);
      nc  = lk ? 8'h00 : (hit ? 8'hFF : {m_cnt[s][6:0], 1'b0});
      sb_q.push_back({hit, nc});
      m_cnt[s] = nc; m_act = hit; m_sel = s;
    end
    if (c) m_act = 0;
    if (w && ok_w) m_pw[ws] = wd;
    @(negedge clk);
    go = 0; wr_en = 0; clr_priv = 0;
  endtask

  task automatic present(logic [3:0] s, logic [23:0] p);
    cycle(1, s, p, 0, 0, 0, 0);
  endtask

  task automatic pwr(logic [3:0] ws, logic [23:0] wd);
    cycle(0, 0, 0, 1, ws, wd, 0);
  endtask

  task automatic chk_priv(string tag);
    logic [7:0] rd, wr;
    rd = m_act ? (8'h1 << m_sel[2:0]) : 8'h0;
    wr = (m_act && !m_sel[3]) ? rd : 8'h0;
    chk({tag, " act_valid"}, act_valid, m_act);
    chk({tag, " rights"}, {set_rd_ok, set_wr_ok}, {rd, wr});
  endtask

  task automatic chk_cnt(string tag, logic [3:0] i);
    cnt_rd_sel = i; #0.5;
    chk(tag, cnt_rd, m_cnt[i]);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_pw[i] = 24'h3C5A00 + 24'(i); m_cnt[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk_priv("R11 reset");
    for (int i = 0; i < 16; i++) chk_cnt("R11 counter after reset", 4'(i));

    // R1 R2 R4 R7: read password of set 3
    present(4'b1011, 24'h3C5A0B); @(negedge clk);
    chk_priv("R7 read password rights");
    // R3 R6: wrong write password 2 cancels read privilege
    present(4'b0010, 24'h000000); @(negedge clk);
    chk_priv("R6 failed presentation cancels");
    chk_cnt("R3 one bit spent", 4'b0010);
    // R4 R7: correct write 2
    present(4'b0010, 24'h3C5A02); @(negedge clk);
    chk_priv("R7 write password rights");
    chk_cnt("R4 counter refilled", 4'b0010);

    // R8: allowed and refused writes
    pwr(4'b0010, 24'h111111);
    pwr(4'b1010, 24'h222222);
    pwr(4'b0101, 24'h999999);
    present(4'b0101, 24'h3C5A05); @(negedge clk);
    chk_priv("R8 write to other set ignored");
    present(4'b0010, 24'h111111); @(negedge clk);
    chk_priv("R8 write password replaced");
    present(4'b1010, 24'h222222); @(negedge clk);
    chk_priv("R8 read password of same set replaced");
    // R8: read privilege alone does not open the port
    pwr(4'b1010, 24'h333333);
    present(4'b1010, 24'h222222); @(negedge clk);
    chk_priv("R8 read privilege cannot write");

    // R3 R5: lock write 6
    for (int k = 0; k < 8; k++) begin
      present(4'b0110, 24'hABCDEF);
      chk_cnt("R3 counter step", 4'b0110);
    end
    present(4'b0100, 24'h3C5A04); @(negedge clk);
    chk_priv("R4 write 4 granted");
    present(4'b0110, 24'h3C5A06); @(negedge clk);
    chk_priv("R5 locked presentation cancels and denies");
    chk_cnt("R5 counter stays zero", 4'b0110);

    // R10 secure code
    present(4'b0111, 24'h3C5A07); @(negedge clk);
    chk_priv("R10 secure code rights");
    chk("R10 set 7 write", set_wr_ok, 8'h80);

    // R9 clear
    cycle(0, 0, 0, 0, 0, 0, 1); @(negedge clk);
    chk_priv("R9 clear alone");
    cycle(1, 4'b0111, 24'h3C5A07, 0, 0, 0, 1); @(negedge clk);
    chk_priv("R9 clear beats grant");

    // R12 collisions
    present(4'b0010, 24'h111111); @(negedge clk);
    cycle(1, 4'b0010, 24'h111111, 1, 4'b0010, 24'h444444, 0); @(negedge clk);
    chk_priv("R12 compare uses old value");
    present(4'b0010, 24'h111111); @(negedge clk);
    chk_priv("R12 old value gone");
    present(4'b0010, 24'h444444); @(negedge clk);
    cycle(1, 4'b1001, 24'h000000, 1, 4'b0010, 24'h555555, 0); @(negedge clk);
    chk_priv("R12 write under cancelled privilege");
    present(4'b0010, 24'h555555); @(negedge clk);
    chk_priv("R12 write took effect");

    // R4 recovery after partial spend
    present(4'b0001, 24'h0); present(4'b0001, 24'h1);
    chk_cnt("R3 two bits spent", 4'b0001);
    present(4'b0001, 24'h3C5A01); @(negedge clk);
    chk_cnt("R4 recovery to full", 4'b0001);

    repeat (3) @(negedge clk);
    chk("R2 all results seen", sb_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule